// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block is the exception and interrupt control for an in-order pipeline with fetch, decode, execute, memory and writeback stages. Each stage that can detect a fault raises a one-cycle flag for the instruction it holds. The controller attaches a tag to that instruction and carries it down the pipe alongside the instruction's PC. Nothing is acted on until the instruction reaches the memory stage, which is the single commit point. Because only one stage ever decides, every older instruction has already committed when a trap is taken, and none of the younger ones has.

When the instruction in the memory stage carries a tag, the controller does four things. It stops that instruction from committing, flushes everything behind it, and records the cause code and the instruction's PC. It then sends fetch to the handler address held in an internal 16-entry vector table, which it indexes by the cause code.

An external interrupt request is taken at the next clean instruction boundary, and only while the global interrupt enable is set. A trap-return request sends fetch back to the saved PC and puts back the enable value that was in force before the trap.

Top module: `trap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all of the following are zero: `ie_q`, `cause_q`, `epc_q`, `redirect_valid`, `commit_valid` and `trap_taken`. No stage holds an instruction.
- R2: When an instruction in the memory stage carries an exception, it does not commit, and neither does any younger instruction. `trap_taken`, `kill_mem`, `flush_younger` and `redirect_valid` are all high in that cycle. Every older instruction has already pulsed `commit_valid`.
- R3: The cause codes are: 0 for a fetch address fault, 1 for an illegal opcode, 2 for divide by zero, 3 for a data address fault, and 8 for an external interrupt. The code is visible on `cause_q` in the cycle after the trap.
- R4: When one instruction is flagged in several stages, the cause recorded is the one from the earliest stage.
- R5: When several in-flight instructions carry exceptions in the same cycle, the trap is taken for the oldest one.
- R6: For a synchronous exception, `epc_q` holds the PC of the faulting instruction in the cycle after the trap.
- R7: In the trap cycle, `redirect_pc` equals the vector table entry at the cause code. A write through `cfg_vec_we`/`cfg_vec_idx`/`cfg_vec_data` replaces that entry for later traps.
- R8: `irq_req` has no effect while `ie_q` is 0. While `ie_q` is 1, the interrupt is taken on the next valid instruction in the memory stage, and that instruction does not commit. Cause 8 is recorded, and `epc_q` receives that instruction's PC. If that instruction has its own exception, the exception wins.
- R9: Trap entry clears `ie_q`. A `ret_req` with no trap in the same cycle raises `redirect_valid` with `redirect_pc` equal to `epc_q`, and restores `ie_q` to its value before the trap.
- R10: Every valid instruction that reaches the memory stage without a trap pulses `commit_valid` for one cycle. A stream with no faults therefore commits every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_pc | input | 32 | PC of the instruction being fetched |
| if_fault | input | 1 | Fetch address fault for the fetched instruction |
| id_illegal | input | 1 | Decode stage found an illegal opcode |
| ex_divzero | input | 1 | Execute stage found a divide by zero |
| mem_badaddr | input | 1 | Memory stage found a bad data address |
| irq_req | input | 1 | External interrupt request (level) |
| ret_req | input | 1 | Trap-return request |
| cfg_vec_we | input | 1 | Vector table write strobe |
| cfg_vec_idx | input | 4 | Vector table entry to write |
| cfg_vec_data | input | 32 | Handler address to write |
| cfg_ie_we | input | 1 | Write strobe for the interrupt enable |
| cfg_ie_val | input | 1 | Value written to the interrupt enable |
| commit_valid | output | 1 | Memory-stage instruction commits this cycle |
| trap_taken | output | 1 | A trap is taken this cycle |
| kill_mem | output | 1 | Memory-stage instruction becomes a bubble |
| flush_younger | output | 1 | Fetch, decode and execute contents become bubbles |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Handler address or return PC |
| cause_q | output | 4 | Recorded cause code |
| epc_q | output | 32 | Saved return PC |
| ie_q | output | 1 | Global interrupt enable |

## Verification
The bench aims at collisions: one instruction flagged in decode and again in memory, and three instructions flagged in different stages in the same cycle. A design that ordered causes by stage instead of by age would report the younger instruction's cause and PC. It also raises an interrupt on the very instruction that faults; a design that let the interrupt win would record cause 8 and lose the exception. With the enable clear, a held interrupt must cause no trap. After entry, the bench keeps the request high; a design that did not clear the enable would trap a second time. A trap return must land on the saved PC and bring the enable back. Finally, rewriting a vector entry must change where the next trap of that cause is sent.

// File: rtl/trap_pkg.sv
// Package: shared tag type, cause encodings and widths for the trap controller.
// Assumes a 32-bit PC and 4-bit cause codes.
package trap_pkg;
    localparam int PC_W    = 32;
    localparam int CAUSE_W = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH   = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_DIVZERO = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_DADDR   = 4'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ     = 4'd8;

    // One instruction slot as it moves through the pipe.
    typedef struct packed {
        logic               valid;
        logic [PC_W-1:0]    pc;
        logic               exc;
        logic [CAUSE_W-1:0] code;
    } slot_tag_t;

    // Cause raised by the stage that follows fetch at position s (0 = decode).
    function automatic logic [CAUSE_W-1:0] stage_cause(input int s);
        case (s)
            0:       return CAUSE_ILLEGAL;
            1:       return CAUSE_DIVZERO;
            default: return CAUSE_DADDR;
        endcase
    endfunction
endpackage

// File: rtl/trap_tag_pipe.sv
// Module: carries PC and exception tag of each in-flight instruction from
// decode to memory. A stage only sets a tag if none is present, so the
// earliest-stage cause of an instruction survives.
// Assumes the pipe advances every cycle; flush turns every slot into a bubble.
module trap_tag_pipe
    import trap_pkg::*;
#(
    parameter int NSTG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  slot_tag_t       fetch_tag,
    input  logic [NSTG-1:0] det,
    output slot_tag_t       mem_tag
);
    for (genvar s = 0; s < NSTG; s++) begin : gen_stg
        slot_tag_t q;
        slot_tag_t m;
        slot_tag_t d;

        // Select the slot entering this stage.
        if (s == 0) begin : g_first
            assign d = fetch_tag;
        end else begin : g_next
            assign d = gen_stg[s-1].m;
        end

        // Merge this stage's detection into the tag, earliest cause kept.
        always_comb begin
            m = q;
            if (q.valid && det[s] && !q.exc) begin
                m.exc  = 1'b1;
                m.code = stage_cause(s);
            end
        end

        // Stage register: cleared by reset or flush, else loads next slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) q <= '0;
            else                 q <= d;
        end
    end

    assign mem_tag = gen_stg[NSTG-1].m;

    for (genvar s = 0; s < NSTG - 1; s++) begin : gen_chk
        assert_tag_travels_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_stg[s].q.valid && gen_stg[s].q.exc && !flush)
            |=> (gen_stg[s+1].q.exc && gen_stg[s+1].q.code == $past(gen_stg[s].q.code)));
    end

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !gen_stg[NSTG-1].q.valid);
endmodule

// File: rtl/trap_vec_table.sv
// Module: handler address table indexed by cause, written through a
// configuration port and read combinationally. Entries reset to zero.
module trap_vec_table #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] entry_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : gen_ent
        // Entry k: cleared by reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  entry_q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))       entry_q[k] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/trap_csr.sv
// Module: cause, saved PC and interrupt-enable state. Trap entry has
// priority over trap return, which has priority over a configuration write.
module trap_csr
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_take,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [PC_W-1:0]    trap_epc,
    input  logic               ret_take,
    input  logic               ie_we,
    input  logic               ie_val,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [PC_W-1:0]    epc_q,
    output logic               ie_q
);
    logic prev_ie_q;

    // Cause and EPC capture on trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (trap_take) begin
            cause_q <= trap_cause;
            epc_q   <= trap_epc;
        end
    end

    // Enable: saved and cleared on entry, restored on return, else writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            prev_ie_q <= 1'b0;
        end else if (trap_take) begin
            prev_ie_q <= ie_q;
            ie_q      <= 1'b0;
        end else if (ret_take) begin
            ie_q      <= prev_ie_q;
        end else if (ie_we) begin
            ie_q      <= ie_val;
        end
    end

    assert_entry_clears_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !ie_q);
    assert_return_keeps_epc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && !trap_take) |=> $stable(epc_q));
endmodule

// File: rtl/trap_ctrl.sv
// Module: top of the precise trap controller. Fetch-stage faults enter as a
// tag; decode, execute and memory detections are merged in the tag pipe.
// The memory stage is the only commit point: a tagged slot there traps; a
// clean slot either commits or, with the enable set, takes an interrupt.
// Assumes the datapath advances one slot per cycle and honours the flush
// and kill outputs in the same cycle they are raised.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int VEC_DEPTH = 16,
    localparam int VIDX_W   = $clog2(VEC_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_valid,
    input  logic [PC_W-1:0]    if_pc,
    input  logic               if_fault,
    input  logic               id_illegal,
    input  logic               ex_divzero,
    input  logic               mem_badaddr,
    input  logic               irq_req,
    input  logic               ret_req,
    input  logic               cfg_vec_we,
    input  logic [VIDX_W-1:0]  cfg_vec_idx,
    input  logic [PC_W-1:0]    cfg_vec_data,
    input  logic               cfg_ie_we,
    input  logic               cfg_ie_val,
    output logic               commit_valid,
    output logic               trap_taken,
    output logic               kill_mem,
    output logic               flush_younger,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [PC_W-1:0]    epc_q,
    output logic               ie_q
);
    localparam int NSTG = 3;

    slot_tag_t          fetch_tag;
    slot_tag_t          mem_tag;
    logic               sync_trap;
    logic               irq_trap;
    logic               ret_take;
    logic [CAUSE_W-1:0] trap_cause;
    logic [PC_W-1:0]    vec_addr;

    // Build the tag of the slot leaving fetch.
    always_comb begin
        fetch_tag.valid = if_valid;
        fetch_tag.pc    = if_pc;
        fetch_tag.exc   = if_valid && if_fault;
        fetch_tag.code  = CAUSE_FETCH;
    end

    trap_tag_pipe #(.NSTG(NSTG)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_younger),
        .fetch_tag (fetch_tag),
        .det       ({mem_badaddr, ex_divzero, id_illegal}),
        .mem_tag   (mem_tag)
    );

    // Commit decision at the memory stage.
    always_comb begin
        sync_trap    = mem_tag.valid && mem_tag.exc;
        irq_trap     = mem_tag.valid && !mem_tag.exc && irq_req && ie_q;
        trap_taken   = sync_trap || irq_trap;
        trap_cause   = sync_trap ? mem_tag.code : CAUSE_IRQ;
        ret_take     = ret_req && !trap_taken;
        commit_valid = mem_tag.valid && !trap_taken;
        kill_mem     = trap_taken;
    end

    trap_vec_table #(.DEPTH(VEC_DEPTH), .W(PC_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_vec_we),
        .wr_idx  (cfg_vec_idx),
        .wr_data (cfg_vec_data),
        .rd_idx  (trap_cause[VIDX_W-1:0]),
        .rd_data (vec_addr)
    );

    trap_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_take  (trap_taken),
        .trap_cause (trap_cause),
        .trap_epc   (mem_tag.pc),
        .ret_take   (ret_take),
        .ie_we      (cfg_ie_we),
        .ie_val     (cfg_ie_val),
        .cause_q    (cause_q),
        .epc_q      (epc_q),
        .ie_q       (ie_q)
    );

    // Fetch steering: handler on a trap, saved PC on a return.
    always_comb begin
        flush_younger  = trap_taken || ret_take;
        redirect_valid = flush_younger;
        redirect_pc    = trap_taken ? vec_addr : epc_q;
    end

    assert_no_commit_after_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !commit_valid);
    assert_epc_is_slot_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> epc_q == $past(mem_tag.pc));
    assert_cause_recorded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> cause_q == $past(trap_cause));
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && cause_q != CAUSE_IRQ && !mem_tag.exc) |-> ie_q);
endmodule

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_valid, if_fault, id_illegal, ex_divzero, mem_badaddr;
    logic [31:0] if_pc;
    logic        irq_req, ret_req, cfg_vec_we, cfg_ie_we, cfg_ie_val;
    logic [3:0]  cfg_vec_idx;
    logic [31:0] cfg_vec_data;
    logic        commit_valid, trap_taken, kill_mem, flush_younger, redirect_valid;
    logic [31:0] redirect_pc, epc_q;
    logic [3:0]  cause_q;
    logic        ie_q;

    always #2.5 clk = ~clk;

    trap_ctrl u_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc), .if_fault(if_fault),
        .id_illegal(id_illegal), .ex_divzero(ex_divzero), .mem_badaddr(mem_badaddr),
        .irq_req(irq_req), .ret_req(ret_req), .cfg_vec_we(cfg_vec_we), .cfg_vec_idx(cfg_vec_idx),
        .cfg_vec_data(cfg_vec_data), .cfg_ie_we(cfg_ie_we), .cfg_ie_val(cfg_ie_val),
        .commit_valid(commit_valid), .trap_taken(trap_taken), .kill_mem(kill_mem),
        .flush_younger(flush_younger), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cause_q(cause_q), .epc_q(epc_q), .ie_q(ie_q)
    );

    typedef struct {
        bit          is_trap;
        logic [3:0]  cause;
        logic [31:0] epc;
        logic [31:0] target;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          commits  = 0;
    int          traps    = 0;
    bit          stop     = 0;
    bit          pend     = 0;
    exp_t        last;
    logic [31:0] vec_model [16];
    bit          exp_ie   = 0;
    bit          exp_prev = 0;
    logic [31:0] exp_epc  = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: counts commits, pops the scoreboard on every redirect.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) continue;
            if (pend) begin
                check(cause_q == last.cause, "R3 cause_q", 32'(cause_q), 32'(last.cause));
                check(epc_q == last.epc, "R6 epc_q", epc_q, last.epc);
                check(ie_q == 1'b0, "R9 ie cleared on entry", 32'(ie_q), 0);
                pend = 0;
            end
            if (commit_valid) commits++;
            if (redirect_valid) begin
                stop = 1;
                if (trap_taken) traps++;
                if (sb_q.size() == 0) begin
                    check(0, "R8 unexpected redirect", redirect_pc, 0);
                end else begin
                    last = sb_q.pop_front();
                    check(trap_taken == last.is_trap, "R2 trap vs return", 32'(trap_taken), 32'(last.is_trap));
                    check(redirect_pc == last.target, "R7 redirect_pc", redirect_pc, last.target);
                    if (last.is_trap) begin
                        check(kill_mem && flush_younger && !commit_valid, "R2 kill and flush",
                              {kill_mem, flush_younger, commit_valid}, 32'b110);
                        pend = 1;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic idle_inputs();
        if_valid = 0; if_pc = 0; if_fault = 0; id_illegal = 0; ex_divzero = 0;
        mem_badaddr = 0; irq_req = 0; ret_req = 0; cfg_vec_we = 0; cfg_vec_idx = 0;
        cfg_vec_data = 0; cfg_ie_we = 0; cfg_ie_val = 0;
    endtask

    task automatic write_vec(input int idx, input logic [31:0] addr);
        @(negedge clk);
        cfg_vec_we = 1; cfg_vec_idx = 4'(idx); cfg_vec_data = addr;
        vec_model[idx] = addr;
        @(negedge clk);
        cfg_vec_we = 0;
    endtask

    task automatic write_ie(input bit v);
        @(negedge clk);
        cfg_ie_we = 1; cfg_ie_val = v; exp_ie = v;
        @(negedge clk);
        cfg_ie_we = 0;
    endtask

    // Driver: stream of n slots; mask bit0..3 = fault in fetch/decode/execute/memory.
    task automatic run_stream(input string req, input int n, input logic [31:0] base,
                              input logic [3:0] m [8], input int irq_cyc, input bit hold);
        int   first_f = n;
        int   irq_i   = -1;
        int   idx;
        int   c0;
        int   t0;
        exp_t e;
        bit   trap_exp = 0;
        for (int i = n - 1; i >= 0; i--) if (m[i] != 0) first_f = i;
        if (irq_cyc >= 3 && exp_ie) irq_i = irq_cyc - 3;
        e.is_trap = 1;
        if (irq_i >= 0 && irq_i < n && irq_i < first_f) begin
            idx = irq_i; e.cause = 4'd8; trap_exp = 1;
        end else if (first_f < n) begin
            idx = first_f; trap_exp = 1;
            e.cause = m[first_f][0] ? 4'd0 : m[first_f][1] ? 4'd1 : m[first_f][2] ? 4'd2 : 4'd3;
        end else begin
            idx = n;
        end
        if (trap_exp) begin
            e.epc = base + 32'(4 * idx);
            e.target = vec_model[e.cause];
            sb_q.push_back(e);
            exp_prev = exp_ie; exp_ie = 0; exp_epc = e.epc;
        end
        c0 = commits; t0 = traps; stop = 0;
        for (int t = 0; t < n + 5; t++) begin
            @(negedge clk);
            if_valid    = (t < n) && !stop;
            if_pc       = base + 32'(4 * t);
            if_fault    = (t < n) ? m[t][0] : 1'b0;
            id_illegal  = (t >= 1 && t - 1 < n) ? m[t-1][1] : 1'b0;
            ex_divzero  = (t >= 2 && t - 2 < n) ? m[t-2][2] : 1'b0;
            mem_badaddr = (t >= 3 && t - 3 < n) ? m[t-3][3] : 1'b0;
            irq_req     = hold ? (irq_cyc >= 0 && t >= irq_cyc) : (t == irq_cyc);
        end
        @(negedge clk);
        idle_inputs();
        repeat (2) @(negedge clk);
        #3;
        check(commits - c0 == idx, {req, " commit count"}, 32'(commits - c0), 32'(idx));
        check(traps - t0 == int'(trap_exp), {req, " trap count"}, 32'(traps - t0), 32'(trap_exp));
    endtask

    task automatic do_return();
        exp_t e;
        e.is_trap = 0; e.cause = 0; e.epc = exp_epc; e.target = exp_epc;
        sb_q.push_back(e);
        @(negedge clk);
        ret_req = 1;
        @(negedge clk);
        ret_req = 0;
        exp_ie = exp_prev;
        #3;
        check(ie_q == exp_ie, "R9 ie restored on return", 32'(ie_q), 32'(exp_ie));
        check(epc_q == exp_epc, "R9 epc kept on return", epc_q, exp_epc);
    endtask

    initial begin
        logic [3:0] m [8];
        idle_inputs();
        for (int k = 0; k < 16; k++) vec_model[k] = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        #3;
        check(ie_q == 0 && cause_q == 0 && epc_q == 0, "R1 reset state",
              {ie_q, cause_q, epc_q[26:0]}, 0);
        check(!redirect_valid && !commit_valid && !trap_taken, "R1 reset outputs",
              {redirect_valid, commit_valid, trap_taken}, 0);
        @(negedge clk);
        rst_n = 1;

        for (int k = 0; k < 16; k++) write_vec(k, 32'h1000 + 32'(k) * 32'h40);
        write_vec(8, 32'h8000);

        // R10 clean stream commits every slot.
        foreach (m[i]) m[i] = 0;
        run_stream("R10 clean stream", 6, 32'h100, m, -1, 0);

        // R2 R3 R6 R7 divide by zero on third slot.
        foreach (m[i]) m[i] = 0;
        m[2] = 4'b0100;
        run_stream("R2 divzero", 6, 32'h200, m, -1, 0);

        // R4 one slot flagged in decode and memory: decode cause wins.
        foreach (m[i]) m[i] = 0;
        m[1] = 4'b1010;
        run_stream("R4 earliest stage", 6, 32'h300, m, -1, 0);

        // R5 three slots flagged in one cycle: oldest wins.
        foreach (m[i]) m[i] = 0;
        m[1] = 4'b1000; m[2] = 4'b0100; m[3] = 4'b0010;
        run_stream("R5 oldest wins", 6, 32'h400, m, -1, 0);

        // R3 fetch fault on first slot.
        foreach (m[i]) m[i] = 0;
        m[0] = 4'b0001;
        run_stream("R3 fetch fault", 4, 32'h500, m, -1, 0);

        // R8 interrupt ignored while enable clear.
        foreach (m[i]) m[i] = 0;
        run_stream("R8 irq masked", 6, 32'h600, m, 0, 1);

        // R8 R9 interrupt taken, held request not retaken.
        write_ie(1);
        run_stream("R8 irq taken", 6, 32'h700, m, 4, 1);
        check(ie_q == 0, "R9 ie after irq", 32'(ie_q), 0);
        do_return();

        // R8 exception on the same slot beats interrupt.
        foreach (m[i]) m[i] = 0;
        m[1] = 4'b1000;
        run_stream("R8 exception beats irq", 6, 32'h800, m, 4, 0);
        do_return();

        // R7 rewritten vector used by next trap.
        write_vec(2, 32'h0000_ABC0);
        foreach (m[i]) m[i] = 0;
        m[0] = 4'b0100;
        run_stream("R7 new vector", 4, 32'h900, m, -1, 0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule